// File: doc/BRIEF.md
# Synchronous Serial Position Output Slave

This block is the serial output stage of a position sensor. An external master drives a serial clock. The first rising edge after idle freezes the current position snapshot: an optional 8-bit period count, an angle value of programmable length, and two error flags. The block then presents that snapshot on a single data line, most significant bit first. Every further rising edge advances one bit. The master is expected to sample the line on its falling edges.

The converter that produces the angle is outside the block. It is modelled as parallel inputs. On the capture edge the block raises a one-cycle hold strobe so that the converter pauses for that cycle. A retriggerable timeout closes each cycle. Its time base is a free-running prescaler that divides the system clock into reference ticks, and a 2-bit code selects its length. If no clock edge arrives within that time, the interface falls back to idle and the next rising edge captures a new snapshot. A recirculating mode can feed every transmitted bit back into the register, so that a master clocking past the end receives the same word again.

The serial clock input is brought into the system clock domain by a parameterised synchroniser chain. All behaviour below is stated at the synchronised edges.

Top module: `ssi_pos_slave`

## Requirements
- R1: After reset, and whenever the interface is idle, `ssi_data_o` is 0 and `conv_hold_o` is 0.
- R2: A rising serial clock edge seen while idle captures the inputs and starts a cycle. `conv_hold_o` is 1 for exactly the one system clock cycle that follows the capture edge. No other edge raises it.
- R3: After the capture edge, `ssi_data_o` shows the most significant bit of the word. Each further rising edge moves to the next lower bit. The word is built from the period field, then the angle field, then the tail field.
- R4: `pc_mode_i` = 1 puts the period field `period_i[7:0]` (8 bits) at the front of the word. Codes 0, 2 and 3 leave the period field out.
- R5: The angle field is `angle_i[N-1:0]`, where N = `ang_res_i`. Values below 2 are treated as 2, and values above 13 are treated as 13.
- R6: `tail_opt_i` codes 0 and 2 append three tail bits in the order `err_i[1]`, `err_i[0]`, 0. Codes 1 and 3 append no tail bits.
- R7: Without recirculation (`tail_opt_i` codes 0 and 1), every rising edge after the last bit of the word gives a 0 stop level on `ssi_data_o`.
- R8: With `tail_opt_i` codes 2 and 3, each transmitted bit is fed back into the low end of the word. Clocking past the end therefore repeats the captured word, and nothing is recaptured before a timeout.
- R9: One reference tick is 32 system clock cycles. `tmo_code_i` 0, 1, 2 and 3 select L = 256, 32, 8 and 2 ticks. When no serial clock edge of either polarity arrives for between L and L+3 ticks, the cycle ends and the interface returns to idle.
- R10: A serial clock pause shorter than L ticks keeps the current cycle alive. The next rising edge advances to the next bit and does not recapture.
- R11: The data and configuration inputs are sampled only at the capture edge. Changes to them during a cycle have no effect on the bits sent in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssi_clk_i | input | 1 | Serial clock from the master |
| ssi_data_o | output | 1 | Serial data, MSB first, low when idle |
| conv_hold_o | output | 1 | One-cycle freeze strobe to the angle converter |
| period_i | input | PC_W (8) | Period counter value |
| angle_i | input | ANG_MAX (13) | Angle value, right-aligned |
| err_i | input | 2 | Error flags, bit 1 sent first |
| pc_mode_i | input | 2 | Period field select (1 = send 8 bits) |
| ang_res_i | input | 4 | Angle field length in bits |
| tail_opt_i | input | 2 | Bit 0 = suppress tail, bit 1 = recirculate |
| tmo_code_i | input | 2 | Timeout length select |

## Verification
Several properties are checked by assertions on every cycle. The hold strobe is a single-cycle pulse and it always accompanies a capture. A rising edge inside a cycle keeps the cycle open. Once a non-recirculating word has been fully shifted out, the line is low. The timeout counter restarts on every edge and stays within its bound. The exact bit sequence of each word composition, the clamping of the angle length, the repetition in recirculating mode, and the position of the timeout inside its L to L+3 tick window can only be shown by the bench's directed and random frames. The same holds for the fact that mid-cycle input changes are ignored.

// File: rtl/ssi_pos_pkg.sv
package ssi_pos_pkg;

   typedef enum logic [1:0] {
      PC_NONE = 2'd0,
      PC_BYTE = 2'd1,
      PC_RSV2 = 2'd2,
      PC_RSV3 = 2'd3
   } pc_mode_e;

   typedef enum logic [1:0] {
      TMO_LONG  = 2'd0,
      TMO_MID   = 2'd1,
      TMO_SHORT = 2'd2,
      TMO_MIN   = 2'd3
   } tmo_code_e;

   // width needed to hold a count up to and including value v
   function automatic int bits_for(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/ssi_frame_pack.sv
module ssi_frame_pack
   import ssi_pos_pkg::*;
#(
   parameter int PC_W    = 8,
   parameter int ANG_MIN = 2,
   parameter int ANG_MAX = 13,
   parameter int TAIL_W  = 3,
   parameter int FW      = PC_W + ANG_MAX + TAIL_W,
   parameter int LEN_W   = 5,
   parameter int RES_W   = 4
) (
   input  logic [PC_W-1:0]    period_i,
   input  logic [ANG_MAX-1:0] angle_i,
   input  logic [1:0]         err_i,
   input  logic [1:0]         pc_mode_i,
   input  logic [RES_W-1:0]   ang_res_i,
   input  logic [1:0]         tail_opt_i,
   output logic [FW-1:0]      word_o,
   output logic [LEN_W-1:0]   len_o,
   output logic               ring_o
);

   generate
      if (TAIL_W != 3) begin : g_bad_tail
         $error("ssi_frame_pack: tail must be two flags plus one zero bit");
      end
      if (ANG_MIN < 1 || ANG_MIN > ANG_MAX) begin : g_bad_ang
         $error("ssi_frame_pack: angle length range is empty");
      end
      if (FW != PC_W + ANG_MAX + TAIL_W) begin : g_bad_fw
         $error("ssi_frame_pack: frame width mismatch");
      end
   endgenerate

   logic [RES_W-1:0] res;
   logic [FW-1:0]    amask;

   // clamp the requested angle length into the supported window
   always_comb begin
      if (ang_res_i < RES_W'(ANG_MIN))      res = RES_W'(ANG_MIN);
      else if (ang_res_i > RES_W'(ANG_MAX)) res = RES_W'(ANG_MAX);
      else                                  res = ang_res_i;
   end

   always_comb begin
      word_o = '0;
      len_o  = '0;
      if (pc_mode_i == PC_BYTE) begin
         word_o = FW'(period_i);
         len_o  = LEN_W'(PC_W);
      end
      amask  = (FW'(1) << res) - FW'(1);
      word_o = (word_o << res) | (FW'(angle_i) & amask);
      len_o  = len_o + LEN_W'(res);
      if (!tail_opt_i[0]) begin
         word_o = (word_o << TAIL_W) | FW'({err_i, 1'b0});
         len_o  = len_o + LEN_W'(TAIL_W);
      end
   end

   assign ring_o = tail_opt_i[1];

endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop
   import ssi_pos_pkg::*;
#(
   parameter int PRESCALE = 32,
   parameter int TMO_T0   = 256,
   parameter int TMO_T1   = 32,
   parameter int TMO_T2   = 8,
   parameter int TMO_T3   = 2,
   parameter int CNT_W    = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       edge_i,
   input  logic [1:0] code_i,
   output logic       expire_o
);

   localparam int PS_W = bits_for(PRESCALE - 1);

   generate
      if (PRESCALE < 1) begin : g_bad_ps
         $error("ssi_monoflop: prescale must be at least 1");
      end
      if (!(TMO_T0 >= TMO_T1 && TMO_T1 >= TMO_T2 && TMO_T2 >= TMO_T3 && TMO_T3 >= 1)) begin : g_bad_t
         $error("ssi_monoflop: timeout codes must be non-increasing and nonzero");
      end
      if (CNT_W < bits_for(TMO_T0 + 1)) begin : g_bad_cw
         $error("ssi_monoflop: counter too narrow");
      end
   endgenerate

   logic             ref_tick;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   // free-running reference divider; its phase is unrelated to the serial clock
   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign ref_tick = 1'b1;
      end else begin : g_div
         logic [PS_W-1:0] ps;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           ps <= '0;
            else if (ps == PS_W'(PRESCALE - 1))   ps <= '0;
            else                                  ps <= ps + PS_W'(1);
         end
         assign ref_tick = (ps == PS_W'(PRESCALE - 1));
      end
   endgenerate

   // one tick of slack absorbs the unknown prescaler phase at the last edge
   always_comb begin
      case (code_i)
         TMO_LONG:  lim = CNT_W'(TMO_T0 + 1);
         TMO_MID:   lim = CNT_W'(TMO_T1 + 1);
         TMO_SHORT: lim = CNT_W'(TMO_T2 + 1);
         default:   lim = CNT_W'(TMO_T3 + 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (edge_i || !run_i)      cnt <= '0;
      else if (ref_tick && cnt < lim) cnt <= cnt + CNT_W'(1);
   end

   assign expire_o = run_i && (cnt >= lim);

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i |=> (cnt == '0));

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(TMO_T0 + 1));

   p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !edge_i && !ref_tick) |=> $stable(cnt));

endmodule

// File: rtl/ssi_shift_core.sv
module ssi_shift_core #(
   parameter int FW      = 24,
   parameter int LEN_W   = 5,
   parameter int MIN_LEN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             expire_i,
   input  logic [FW-1:0]    word_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             ring_i,
   output logic             dout_o,
   output logic             hold_o,
   output logic             active_o
);

   generate
      if (MIN_LEN < 1 || MIN_LEN > FW) begin : g_bad_len
         $error("ssi_shift_core: minimum length out of range");
      end
   endgenerate

   logic             active;
   logic             hold;
   logic             ring_q;
   logic [FW-1:0]    sr;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] pos;
   logic             top_bit;

   assign top_bit = sr[len_q - LEN_W'(1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         hold   <= 1'b0;
         ring_q <= 1'b0;
         sr     <= '0;
         len_q  <= LEN_W'(MIN_LEN);
         pos    <= '0;
      end else begin
         hold <= 1'b0;
         if (rise_i && !active) begin
            active <= 1'b1;
            hold   <= 1'b1;
            sr     <= word_i;
            len_q  <= len_i;
            ring_q <= ring_i;
            pos    <= '0;
         end else if (rise_i) begin
            sr <= {sr[FW-2:0], ring_q ? top_bit : 1'b0};
            if (pos < len_q) pos <= pos + LEN_W'(1);
         end else if (expire_i) begin
            active <= 1'b0;
         end
      end
   end

   assign dout_o   = active && top_bit;
   assign hold_o   = hold;
   assign active_o = active;

   p_hold_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !hold);

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && !active) |=> (active && hold));

   p_continue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && active) |=> (active && !hold));

   p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ring_q && pos == len_q) |-> !dout_o);

   p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (len_q >= LEN_W'(MIN_LEN) && len_q <= LEN_W'(FW)));

endmodule

// File: rtl/ssi_pos_slave.sv
module ssi_pos_slave
   import ssi_pos_pkg::*;
#(
   parameter int PC_W     = 8,
   parameter int ANG_MIN  = 2,
   parameter int ANG_MAX  = 13,
   parameter int TAIL_W   = 3,
   parameter int SYNC     = 2,
   parameter int PRESCALE = 32,
   parameter int TMO_T0   = 256,
   parameter int TMO_T1   = 32,
   parameter int TMO_T2   = 8,
   parameter int TMO_T3   = 2,
   parameter int RES_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ssi_clk_i,
   output logic               ssi_data_o,
   output logic               conv_hold_o,
   input  logic [PC_W-1:0]    period_i,
   input  logic [ANG_MAX-1:0] angle_i,
   input  logic [1:0]         err_i,
   input  logic [1:0]         pc_mode_i,
   input  logic [RES_W-1:0]   ang_res_i,
   input  logic [1:0]         tail_opt_i,
   input  logic [1:0]         tmo_code_i
);

   localparam int FW    = PC_W + ANG_MAX + TAIL_W;
   localparam int LEN_W = bits_for(FW);
   localparam int CNT_W = bits_for(TMO_T0 + 1);

   generate
      if (SYNC < 1) begin : g_bad_sync
         $error("ssi_pos_slave: at least one synchroniser stage required");
      end
      if (RES_W < bits_for(ANG_MAX)) begin : g_bad_res
         $error("ssi_pos_slave: resolution field too narrow");
      end
   endgenerate

   logic [SYNC-1:0]  sync_q;
   logic             sclk_q;
   logic             sclk_rise;
   logic             sclk_edge;
   logic [FW-1:0]    word;
   logic [LEN_W-1:0] len;
   logic             ring;
   logic             active;
   logic             expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= ssi_clk_i;
   end

   generate
      for (genvar i = 1; i < SYNC; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sync_q[SYNC-1];
   end

   assign sclk_rise = sync_q[SYNC-1] && !sclk_q;
   assign sclk_edge = sync_q[SYNC-1] ^ sclk_q;

   ssi_frame_pack #(
      .PC_W(PC_W), .ANG_MIN(ANG_MIN), .ANG_MAX(ANG_MAX), .TAIL_W(TAIL_W),
      .FW(FW), .LEN_W(LEN_W), .RES_W(RES_W)
   ) u_pack (
      .period_i  (period_i),
      .angle_i   (angle_i),
      .err_i     (err_i),
      .pc_mode_i (pc_mode_i),
      .ang_res_i (ang_res_i),
      .tail_opt_i(tail_opt_i),
      .word_o    (word),
      .len_o     (len),
      .ring_o    (ring)
   );

   ssi_monoflop #(
      .PRESCALE(PRESCALE), .TMO_T0(TMO_T0), .TMO_T1(TMO_T1),
      .TMO_T2(TMO_T2), .TMO_T3(TMO_T3), .CNT_W(CNT_W)
   ) u_mono (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (active),
      .edge_i  (sclk_edge),
      .code_i  (tmo_code_i),
      .expire_o(expire)
   );

   ssi_shift_core #(
      .FW(FW), .LEN_W(LEN_W), .MIN_LEN(ANG_MIN)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (sclk_rise),
      .expire_i(expire),
      .word_i  (word),
      .len_i   (len),
      .ring_i  (ring),
      .dout_o  (ssi_data_o),
      .hold_o  (conv_hold_o),
      .active_o(active)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !sclk_rise) |=> (!conv_hold_o && !ssi_data_o));

endmodule

// File: tb/tb_ssi_pos_slave.sv
module tb_ssi_pos_slave;

   localparam int SYNC = 2;
   localparam int PS   = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        dout, hold;
   logic [7:0]  period = '0;
   logic [12:0] angle = '0;
   logic [1:0]  err = '0;
   logic [1:0]  pc_mode = '0;
   logic [3:0]  ang_res = 4'd2;
   logic [1:0]  tail_opt = '0;
   logic [1:0]  tmo_code = 2'd3;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ssi_pos_slave dut (
      .clk(clk), .rst_n(rst_n), .ssi_clk_i(sclk), .ssi_data_o(dout),
      .conv_hold_o(hold), .period_i(period), .angle_i(angle), .err_i(err),
      .pc_mode_i(pc_mode), .ang_res_i(ang_res), .tail_opt_i(tail_opt),
      .tmo_code_i(tmo_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int ticks_of(input int code);
      case (code)
         0: return 256;
         1: return 32;
         2: return 8;
         default: return 2;
      endcase
   endfunction

   // expected word from the requirement text
   function automatic void model(input int pc, input int res, input int tl,
                                 input logic [7:0] p, input logic [12:0] a,
                                 input logic [1:0] e,
                                 output logic [23:0] w, output int n);
      int r;
      r = (res < 2) ? 2 : ((res > 13) ? 13 : res);
      w = '0;
      n = 0;
      if (pc == 1) begin w = {16'd0, p}; n = 8; end
      for (int i = r - 1; i >= 0; i--) begin w = {w[22:0], a[i]}; n++; end
      if (tl == 0 || tl == 2) begin
         w = {w[22:0], e[1]};
         w = {w[22:0], e[0]};
         w = {w[22:0], 1'b0};
         n += 3;
      end
   endfunction

   // one serial clock pulse: returns data and hold right after the rising edge
   task automatic pulse(output logic d, output logic h, output logic h2);
      sclk = 1'b1;
      wait_cyc(SYNC + 1);
      d = dout;
      h = hold;
      wait_cyc(1);
      h2 = hold;
      sclk = 1'b0;
      wait_cyc(4);
   endtask

   task automatic idle_check(input int code, input string req);
      wait_cyc((ticks_of(code) + 4) * PS);
      chk(dout == 1'b0, req, dout, 0);
      chk(hold == 1'b0, req, hold, 0);
   endtask

   task automatic run_frame(input int pc, input int res, input int tl,
                            input logic [7:0] p, input logic [12:0] a,
                            input logic [1:0] e, input int extra);
      logic [23:0] w;
      int n;
      logic d, h, h2, ex;
      bit ring;
      model(pc, res, tl, p, a, e, w, n);
      ring = (tl >= 2);
      period = p; angle = a; err = e;
      pc_mode = 2'(pc); ang_res = 4'(res); tail_opt = 2'(tl);
      for (int k = 0; k < n + extra; k++) begin
         pulse(d, h, h2);
         if (k < n)      ex = w[n-1-k];
         else if (ring)  ex = w[n-1-(k % n)];
         else            ex = 1'b0;
         if (k < n)      chk(d === ex, "R3 frame bit", d, ex);
         else if (ring)  chk(d === ex, "R8 ring repeat", d, ex);
         else            chk(d === ex, "R7 stop level", d, ex);
         chk(h === (k == 0), "R2 hold strobe", h, (k == 0));
         chk(h2 === 1'b0, "R2 hold width", h2, 0);
         if (k == 0) begin
            // R11: disturb every input after capture
            period = 8'($urandom); angle = 13'($urandom); err = 2'($urandom);
            pc_mode = 2'($urandom); ang_res = 4'($urandom); tail_opt = 2'($urandom);
         end
      end
   endtask

   // R9/R10: pause just short of L ticks keeps the cycle, a longer pause restarts it
   task automatic timeout_probe(input int code);
      logic d, h, h2;
      int lt;
      lt = ticks_of(code);
      tmo_code = 2'(code);
      pc_mode = 2'd0; ang_res = 4'd2; tail_opt = 2'd1; angle = 13'b10;
      pulse(d, h, h2);
      chk(d == 1'b1 && h == 1'b1, "R9 probe start", d, 1);
      angle = 13'b11;
      wait_cyc(lt * PS - 8);
      pulse(d, h, h2);
      chk(d == 1'b0, "R10 short pause keeps cycle", d, 0);
      chk(h == 1'b0, "R10 no recapture strobe", h, 0);
      idle_check(code, "R9 idle after timeout");
      angle = 13'b10;
      pulse(d, h, h2);
      angle = 13'b11;
      wait_cyc((lt + 3) * PS);
      pulse(d, h, h2);
      chk(d == 1'b1, "R9 long pause restarts", d, 1);
      chk(h == 1'b1, "R9 recapture strobe", h, 1);
      idle_check(code, "R9 idle after timeout");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7341));
      wait_cyc(3);
      chk(dout == 1'b0, "R1 reset data", dout, 0);
      chk(hold == 1'b0, "R1 reset hold", hold, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk(dout == 1'b0, "R1 idle data", dout, 0);

      tmo_code = 2'd3;
      // R4 R6: full word, period + 13-bit angle + tail
      run_frame(1, 13, 0, 8'hA5, 13'h1ABC, 2'b10, 2);
      idle_check(3, "R1 idle");
      // R4: reserved period code, R5: length clamp low
      run_frame(2, 0, 1, 8'hFF, 13'h1FFE, 2'b11, 2);
      idle_check(3, "R1 idle");
      run_frame(3, 1, 0, 8'hFF, 13'h0001, 2'b01, 1);
      idle_check(3, "R1 idle");
      // R5: length clamp high
      run_frame(0, 15, 1, 8'h00, 13'h1555, 2'b00, 2);
      idle_check(3, "R1 idle");
      // R8: ring mode with and without tail
      run_frame(0, 5, 2, 8'h00, 13'h0013, 2'b10, 13);
      idle_check(3, "R1 idle");
      run_frame(1, 3, 3, 8'h96, 13'h0005, 2'b00, 17);
      idle_check(3, "R1 idle");

      for (int c = 3; c >= 0; c--) timeout_probe(c);

      for (int f = 0; f < 40; f++) begin
         int pc, res, tl, tc, n, extra;
         logic [23:0] w;
         pc = $urandom_range(0, 3); res = $urandom_range(0, 15);
         tl = $urandom_range(0, 3); tc = $urandom_range(1, 3);
         tmo_code = 2'(tc);
         model(pc, res, tl, 8'h00, 13'h0, 2'b00, w, n);
         extra = (tl >= 2) ? $urandom_range(1, n) : 2;
         run_frame(pc, res, tl, 8'($urandom), 13'($urandom), 2'($urandom), extra);
         tmo_code = 2'(tc);
         idle_check(tc, "R1 idle");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule